// File: doc/BRIEF.md
# Index-Addressed Data Memory with Auto-Increment

This block is a 4096-byte data store that the datapath never addresses directly. All memory traffic goes through a 12-bit index counter. Software loads that counter in two pieces from the 8-bit data bus: a low byte and a high nibble. It can read either piece back onto the bus, so the index can serve as a loop pointer without a copy kept anywhere else. A separate increment enable, driven by one microcode bit, advances the whole index on a clock edge. A run of sequential reads or writes therefore needs no reload of the address.

Reads drive the addressed byte onto the shared bus only while the read strobe is high. Writes go through a holding register. The byte and the index are captured at one edge, and the byte is stored at the next edge, so an increment in the strobe cycle does not disturb the write. Storage is split into two equal banks, and the top index bit chooses between them. The bus is split into an input path and a gated output path with an enable.

Top module: `idx_ram`

## Requirements
- R1: After reset the index is 0x000, bus_oe_o is low and bus_o is 0x00.
- R2: With ld_lo_i high, index bits 7:0 take bus_i[7:0] at the clock edge, and bits 11:8 keep their value when inc_i is low.
- R3: With ld_hi_i high, index bits 11:8 take bus_i[3:0] at the clock edge. bus_i[7:4] has no effect, and bits 7:0 keep their value when inc_i is low.
- R4: With inc_i high and no load, the full 12-bit index rises by one at the edge, with carry from bit 7 into bit 8. It wraps from 0xFFF to 0x000. The increment works whether or not a memory access is active.
- R5: When a load and inc_i coincide, the loaded part takes the bus value. The part not loaded takes the value it would have had from the increment of the old index, including any carry.
- R6: rd_lo_i drives index bits 7:0 onto bus_o. rd_hi_i drives {4'b0000, index[11:8]}.
- R7: mem_rd_i drives the byte stored at the current index onto bus_o in the same cycle.
- R8: bus_oe_o is high exactly when at least one of mem_rd_i, rd_lo_i or rd_hi_i is high, and bus_o is 0x00 otherwise. When several are high, the source priority is mem_rd_i, then rd_lo_i, then rd_hi_i.
- R9: mem_wr_i captures bus_i and the current index at the clock edge. The byte is stored at that captured address at the following edge, even if the index has moved. It is visible to a read two cycles after the strobe cycle, and a read in the cycle right after the strobe still returns the old byte. Back-to-back writes in consecutive cycles are all stored.
- R10: Index bit 11 selects one of two 2048-byte banks, so the addresses A and A XOR 0x800 hold independent bytes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_i | input | 8 | Data bus value from the datapath |
| ld_lo_i | input | 1 | Load index bits 7:0 from bus_i |
| ld_hi_i | input | 1 | Load index bits 11:8 from bus_i[3:0] |
| inc_i | input | 1 | Advance the index by one |
| rd_lo_i | input | 1 | Drive the low index byte onto the bus |
| rd_hi_i | input | 1 | Drive the zero-padded high index nibble onto the bus |
| mem_rd_i | input | 1 | Drive the memory byte at the index onto the bus |
| mem_wr_i | input | 1 | Capture bus_i for a write at the current index |
| bus_o | output | 8 | Gated bus output, 0x00 when not driving |
| bus_oe_o | output | 1 | Bus driver enable |

## Verification
Every low-byte value is loaded under a fixed high nibble, and every high-nibble value is loaded with junk in bus bits 7:4. Read-back of these values separates the load paths from each other and from the zero padding. A sweep of 4097 consecutive increments passes every carry from bit 7 and the wrap from 0xFFF. Loads that coincide with increments at the carry boundary show whether the part not loaded still takes the carry.

The whole memory is filled by back-to-back writes that also increment in the same cycle, and each byte follows an address-dependent pattern. Reading it back shows whether a write used the old address and whether any write in the pipeline was lost. Directed writes at the two bank-aliased addresses check the bank split. A read in the cycle right after a write, and another a cycle later, pin down when a stored byte becomes visible. Strobes raised together check the output priority.

// File: rtl/idx_ram_pkg.sv
package idx_ram_pkg;
  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_MEM  = 2'd1,
    SRC_LO   = 2'd2,
    SRC_HI   = 2'd3
  } bus_src_e;
endpackage

// File: rtl/idx_counter.sv
module idx_counter #(
  parameter int LO_W = 8,
  parameter int HI_W = 4,
  parameter int BUS_W = 8,
  localparam int IDX_W = LO_W + HI_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [BUS_W-1:0] bus_i,
  input  logic             ld_lo_i,
  input  logic             ld_hi_i,
  input  logic             inc_i,
  output logic [IDX_W-1:0] idx_o
);
  logic [IDX_W-1:0] idx_q, idx_d;

  // increment first, then let a load override its own part
  always_comb begin
    idx_d = inc_i ? idx_q + IDX_W'(1) : idx_q;
    if (ld_lo_i) idx_d[LO_W-1:0] = bus_i[LO_W-1:0];
    if (ld_hi_i) idx_d[IDX_W-1:LO_W] = bus_i[HI_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) idx_q <= '0;
    else         idx_q <= idx_d;
  end

  assign idx_o = idx_q;

  p_inc_step_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && !ld_lo_i && !ld_hi_i) |=> idx_q == $past(idx_q) + IDX_W'(1));
  p_wrap_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && !ld_lo_i && !ld_hi_i && (&idx_q)) |=> idx_q == '0);
  p_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!inc_i && !ld_lo_i && !ld_hi_i) |=> $stable(idx_q));
  p_ld_lo_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_lo_i |=> idx_q[LO_W-1:0] == $past(bus_i[LO_W-1:0]));
  p_ld_hi_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_hi_i |=> idx_q[IDX_W-1:LO_W] == $past(bus_i[HI_W-1:0]));
  p_lo_keeps_hi_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ld_lo_i && !ld_hi_i && !inc_i) |=> $stable(idx_q[IDX_W-1:LO_W]));
endmodule

// File: rtl/wr_stage.sv
module wr_stage #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mem_wr_i,
  input  logic [DATA_W-1:0] bus_i,
  input  logic [ADDR_W-1:0] idx_i,
  output logic              we_o,
  output logic [ADDR_W-1:0] waddr_o,
  output logic [DATA_W-1:0] wdata_o
);
  logic              we_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] hold_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      we_q   <= 1'b0;
      addr_q <= '0;
      hold_q <= '0;
    end else begin
      we_q <= mem_wr_i;
      if (mem_wr_i) begin
        addr_q <= idx_i;
        hold_q <= bus_i;
      end
    end
  end

  assign we_o    = we_q;
  assign waddr_o = addr_q;
  assign wdata_o = hold_q;

  p_we_follows_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_wr_i |=> we_o && waddr_o == $past(idx_i) && wdata_o == $past(bus_i));
  p_we_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_wr_i |=> !we_o);
endmodule

// File: rtl/ram_banks.sv
module ram_banks #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 8,
  parameter int NUM_BANKS = 2,
  localparam int SEL_W = $clog2(NUM_BANKS),
  localparam int BANK_AW = ADDR_W - SEL_W,
  localparam int BANK_DEPTH = 1 << BANK_AW
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] rd_bank [NUM_BANKS];
  logic [SEL_W-1:0]  wsel, rsel;
  logic [BANK_AW-1:0] wofs, rofs;

  assign wsel = waddr_i[ADDR_W-1 -: SEL_W];
  assign rsel = raddr_i[ADDR_W-1 -: SEL_W];
  assign wofs = waddr_i[BANK_AW-1:0];
  assign rofs = raddr_i[BANK_AW-1:0];

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic [DATA_W-1:0] mem [BANK_DEPTH];
    always_ff @(posedge clk_i) begin
      if (we_i && wsel == SEL_W'(b)) mem[wofs] <= wdata_i;
    end
    assign rd_bank[b] = mem[rofs];
  end

  assign rdata_o = rd_bank[rsel];
endmodule

// File: rtl/bus_drv.sv
module bus_drv
  import idx_ram_pkg::*;
#(
  parameter int BUS_W = 8,
  parameter int LO_W = 8,
  parameter int HI_W = 4,
  localparam int IDX_W = LO_W + HI_W
) (
  input  logic             mem_rd_i,
  input  logic             rd_lo_i,
  input  logic             rd_hi_i,
  input  logic [BUS_W-1:0] rdata_i,
  input  logic [IDX_W-1:0] idx_i,
  output logic [BUS_W-1:0] bus_o,
  output logic             bus_oe_o
);
  bus_src_e src;

  always_comb begin
    if (mem_rd_i)     src = SRC_MEM;
    else if (rd_lo_i) src = SRC_LO;
    else if (rd_hi_i) src = SRC_HI;
    else              src = SRC_NONE;
  end

  always_comb begin
    unique case (src)
      SRC_MEM:  bus_o = rdata_i;
      SRC_LO:   bus_o = BUS_W'(idx_i[LO_W-1:0]);
      SRC_HI:   bus_o = BUS_W'(idx_i[IDX_W-1:LO_W]);
      default:  bus_o = '0;
    endcase
  end

  assign bus_oe_o = (src != SRC_NONE);
endmodule

// File: rtl/idx_ram.sv
module idx_ram #(
  parameter int BUS_W = 8,
  parameter int HI_W = 4,
  parameter int NUM_BANKS = 2,
  localparam int LO_W = BUS_W,
  localparam int IDX_W = LO_W + HI_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [BUS_W-1:0] bus_i,
  input  logic             ld_lo_i,
  input  logic             ld_hi_i,
  input  logic             inc_i,
  input  logic             rd_lo_i,
  input  logic             rd_hi_i,
  input  logic             mem_rd_i,
  input  logic             mem_wr_i,
  output logic [BUS_W-1:0] bus_o,
  output logic             bus_oe_o
);
  logic [IDX_W-1:0] idx;
  logic             we;
  logic [IDX_W-1:0] waddr;
  logic [BUS_W-1:0] wdata, rdata;

  idx_counter #(.LO_W(LO_W), .HI_W(HI_W), .BUS_W(BUS_W)) u_idx (
    .clk_i, .rst_ni, .bus_i, .ld_lo_i, .ld_hi_i, .inc_i, .idx_o(idx)
  );

  wr_stage #(.ADDR_W(IDX_W), .DATA_W(BUS_W)) u_wr (
    .clk_i, .rst_ni, .mem_wr_i, .bus_i, .idx_i(idx),
    .we_o(we), .waddr_o(waddr), .wdata_o(wdata)
  );

  ram_banks #(.ADDR_W(IDX_W), .DATA_W(BUS_W), .NUM_BANKS(NUM_BANKS)) u_ram (
    .clk_i, .we_i(we), .waddr_i(waddr), .wdata_i(wdata),
    .raddr_i(idx), .rdata_o(rdata)
  );

  bus_drv #(.BUS_W(BUS_W), .LO_W(LO_W), .HI_W(HI_W)) u_bus (
    .mem_rd_i, .rd_lo_i, .rd_hi_i, .rdata_i(rdata), .idx_i(idx),
    .bus_o, .bus_oe_o
  );

  p_idle_bus_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_rd_i || rd_lo_i || rd_hi_i) |-> (!bus_oe_o && bus_o == '0));
  p_drive_en_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_rd_i || rd_lo_i || rd_hi_i) |-> bus_oe_o);
  p_hi_pad_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_hi_i && !rd_lo_i && !mem_rd_i) |-> bus_o[BUS_W-1:HI_W] == '0);
endmodule

// File: tb/idx_ram_tb_top.sv
`timescale 1ns/1ps
module idx_ram_tb_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [7:0] bus_i = '0;
  logic       ld_lo_i = 0, ld_hi_i = 0, inc_i = 0;
  logic       rd_lo_i = 0, rd_hi_i = 0, mem_rd_i = 0, mem_wr_i = 0;
  logic [7:0] bus_o;
  logic       bus_oe_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk_i = ~clk_i;

  idx_ram dut_i (.*);

  function automatic logic [7:0] pat(int a);
    return 8'((a * 37) ^ (a >> 4) ^ 8'h5A);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk_i);
    #1;
  endtask

  task automatic idle();
    ld_lo_i = 0; ld_hi_i = 0; inc_i = 0;
    rd_lo_i = 0; rd_hi_i = 0; mem_rd_i = 0; mem_wr_i = 0;
  endtask

  task automatic load_idx(int v);
    idle();
    bus_i = 8'(v); ld_lo_i = 1; tick();
    ld_lo_i = 0; bus_i = 8'(v >> 8); ld_hi_i = 1; tick();
    idle();
  endtask

  task automatic read_idx(output int v);
    logic [7:0] lo, hi;
    rd_lo_i = 1; #0.2; lo = bus_o;
    rd_lo_i = 0; rd_hi_i = 1; #0.2; hi = bus_o;
    rd_hi_i = 0; #0.2;
    v = {hi, lo};
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: run hung actual=timeout expected=completion");
      summary();
    end
  end

  initial begin
    int v;
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1;
    tick();

    // R1 reset state
    chk("R1 bus_oe", bus_oe_o, 0);
    chk("R1 bus", bus_o, 0);
    read_idx(v);
    chk("R1 index", v, 0);

    // R2 every low value under high nibble 0xA
    load_idx(12'hA00);
    for (int lo = 0; lo < 256; lo++) begin
      bus_i = 8'(lo); ld_lo_i = 1; tick(); idle();
      read_idx(v);
      chk("R2 low load", v, 32'hA00 | lo);
    end

    // R3/R6 every high value with junk in bits 7:4
    for (int h = 0; h < 16; h++) begin
      bus_i = {4'(~h), 4'(h)}; ld_hi_i = 1; tick(); idle();
      read_idx(v);
      chk("R3 high load", v, (h << 8) | 32'hFF);
      rd_hi_i = 1; #0.2;
      chk("R6 high pad", bus_o, h);
      rd_hi_i = 0;
    end

    // R4 full increment sweep including wrap
    load_idx(0);
    inc_i = 1;
    for (int k = 1; k <= 4097; k++) begin
      tick();
      read_idx(v);
      chk("R4 increment", v, k & 12'hFFF);
    end
    idle();

    // R5 load with increment at a carry boundary
    load_idx(12'h0FF);
    bus_i = 8'h03; ld_hi_i = 1; inc_i = 1; tick(); idle();
    read_idx(v);
    chk("R5 hi load + inc", v, 12'h300);
    load_idx(12'h1FF);
    bus_i = 8'h42; ld_lo_i = 1; inc_i = 1; tick(); idle();
    read_idx(v);
    chk("R5 lo load + inc carry", v, 12'h242);

    // R9 fill all with back-to-back writes while incrementing
    load_idx(0);
    for (int a = 0; a < 4096; a++) begin
      bus_i = pat(a); mem_wr_i = 1; inc_i = 1; tick();
    end
    idle(); tick(); tick();
    read_idx(v);
    chk("R4 wrap after fill", v, 0);

    // R7/R9 read back with auto-increment
    for (int a = 0; a < 4096; a++) begin
      mem_rd_i = 1; inc_i = 1; #0.2;
      chk("R7 read", bus_o, pat(a));
      chk("R8 oe on read", bus_oe_o, 1);
      tick();
    end
    idle(); #0.2;
    chk("R8 idle bus", bus_o, 0);
    chk("R8 idle oe", bus_oe_o, 0);

    // R9 old address used when increment coincides
    load_idx(12'h050);
    bus_i = 8'hC3; mem_wr_i = 1; inc_i = 1; tick(); idle(); tick();
    mem_rd_i = 1; #0.2;
    chk("R9 neighbour untouched", bus_o, pat(12'h051));
    mem_rd_i = 0;
    load_idx(12'h050);
    mem_rd_i = 1; #0.2;
    chk("R9 write at old addr", bus_o, 8'hC3);
    idle();

    // R9 visibility timing
    load_idx(12'h200);
    bus_i = 8'h77; mem_wr_i = 1; tick(); idle();
    mem_rd_i = 1; #0.2;
    chk("R9 not yet visible", bus_o, pat(12'h200));
    tick(); #0.2;
    chk("R9 visible", bus_o, 8'h77);
    idle();

    // R10 bank aliasing
    load_idx(12'h123);
    bus_i = 8'h11; mem_wr_i = 1; tick(); idle();
    load_idx(12'h923);
    bus_i = 8'hEE; mem_wr_i = 1; tick(); idle(); tick();
    mem_rd_i = 1; #0.2;
    chk("R10 upper bank", bus_o, 8'hEE);
    idle();
    load_idx(12'h123);
    mem_rd_i = 1; #0.2;
    chk("R10 lower bank", bus_o, 8'h11);

    // R8 priority
    rd_lo_i = 1; rd_hi_i = 1; #0.2;
    chk("R8 mem over index", bus_o, 8'h11);
    mem_rd_i = 0; #0.2;
    chk("R8 lo over hi", bus_o, 8'h23);
    rd_lo_i = 0; #0.2;
    chk("R8 hi alone", bus_o, 8'h01);
    idle();

    done = 1;
    summary();
  end
endmodule